// File: doc/BRIEF.md
# Translation Buffer with Two-Level Table Walker

This block turns 32-bit virtual addresses into physical addresses for a client that issues one translation at a time. It keeps a small fully associative set of recently used translations. Each one is a 20-bit virtual page number paired with a 20-bit physical frame number. When a request's page number is held there, the physical address is returned on the next cycle. It is formed by joining the cached frame number with the low 12 bits of the virtual address.

When the page number is not held, the block walks a two-level table in memory through a simple request/response port. The upper 10 address bits (31:22) index a directory whose base frame comes from the `dir_base` input. The directory word's upper 20 bits give the frame of a page table. The middle 10 bits (21:12) then index that table. Every table word is 4 bytes wide, so its byte address is base plus index times 4. Bit 0 of each table word marks it present. A missing directory or table word ends the walk with a page-fault response and leaves nothing cached. A good walk stores the translation and returns the physical address.

Software can drop every cached translation in one cycle with `flush`, or drop one page number with `inval_valid`. Only one walk is in flight at a time. New requests are held off with `req_ready` low until the walk finishes.

Top module: `xlate_tlb`

## Requirements
- R1: A request accepted (`req_valid` and `req_ready` high at a clock edge) whose page number is cached gives `rsp_valid`=1, `rsp_hit`=1, `rsp_fault`=0 in the very next cycle, with `rsp_paddr` = {cached frame, `req_vaddr[11:0]`}, and no memory read.
- R2: An accepted request that misses first reads the directory word at byte address {`dir_base`, `req_vaddr[31:22]`, 2'b00}.
- R3: If bit 0 of the directory word is 1, the next read is the table word at {directory word[31:12], `req_vaddr[21:12]`, 2'b00}.
- R4: If bit 0 of the table word is 1, the response has `rsp_hit`=0, `rsp_fault`=0 and `rsp_paddr` = {table word[31:12], offset}, one cycle after the table word arrives. The translation is then cached, so a repeat request to that page hits.
- R5: A directory word with bit 0 = 0 ends the walk after that one read with `rsp_fault`=1, `rsp_hit`=0, `rsp_paddr`=0, and caches nothing.
- R6: A table word with bit 0 = 0 gives `rsp_fault`=1, `rsp_hit`=0, `rsp_paddr`=0, and caches nothing.
- R7: At most one cached entry matches any page number.
- R8: A fill goes to the lowest-numbered empty slot. When all 16 slots are full, it goes to a round-robin victim that starts at slot 0 and advances by one after each such replacement.
- R9: `flush` high for one cycle empties every slot at that edge, and wins over a fill at the same edge.
- R10: `inval_valid` empties only the slot holding `inval_vpn`, and leaves every other slot cached.
- R11: `req_ready` is 0 from the cycle after a missing request is accepted until the cycle its response is valid. A request held during a walk is neither accepted nor starts a read.
- R12: `mem_req_valid` and `mem_req_addr` hold steady until `mem_rsp_valid` is seen. `mem_rsp_valid` completes the read in the cycle it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Request can be accepted (no walk in flight) |
| dir_base | input | 20 | Frame number of the page directory |
| flush | input | 1 | Empty all cached translations |
| inval_valid | input | 1 | Empty the slot holding `inval_vpn` |
| inval_vpn | input | 20 | Page number to invalidate |
| rsp_valid | output | 1 | Response valid for one cycle |
| rsp_hit | output | 1 | Response came from the cached set |
| rsp_fault | output | 1 | Page fault (a walked word was not present) |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| mem_req_valid | output | 1 | Table word read request |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data valid, completes the read |
| mem_rsp_data | input | 32 | Read data |

## Verification
The hardest situation to reach from the ports is round-robin replacement. Every slot must first be filled with distinct present pages, and faulting pages must not consume slots. After that, the victim order must be observed through which later requests miss. The stimulus reaches it with a directed fill of sixteen distinct pages, an overflow fill, and probes of the evicted and surviving pages. Random traffic then follows over a 72-page pool with flushes and invalidates, so the pool is larger than the buffer. A bench-side memory model with varying response delay drives the walks, and holding `req_valid` high during walks exercises the stall.

// File: rtl/tlbw_pkg.sv
package tlbw_pkg;
  localparam int VA_W   = 32;
  localparam int OFF_W  = 12;
  localparam int IDX_W  = 10;
  localparam int PN_W   = VA_W - OFF_W;

  typedef struct packed {
    logic [PN_W-1:0] vpn;
    logic [PN_W-1:0] pfn;
  } tlb_ent_t;

  typedef enum logic [1:0] {
    WK_IDLE = 2'd0,
    WK_DIR  = 2'd1,
    WK_TBL  = 2'd2
  } walk_st_t;
endpackage

// File: rtl/tlbw_cam.sv
module tlbw_cam
  import tlbw_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PN_W-1:0]    look_vpn,
  output logic               look_hit,
  output logic [PN_W-1:0]    look_pfn,
  input  logic               flush,
  input  logic               inval_valid,
  input  logic [PN_W-1:0]    inval_vpn,
  input  logic               fill_en,
  input  logic [PN_W-1:0]    fill_vpn,
  input  logic [PN_W-1:0]    fill_pfn,
  output logic [ENTRIES-1:0] match_vec,
  output logic [ENTRIES-1:0] valid_vec
);
  tlb_ent_t            ent_q [ENTRIES];
  logic [ENTRIES-1:0]  valid_q, valid_d, kill_vec;
  logic [PTR_W-1:0]    rr_q, rr_d, victim;
  logic                use_rr;

  // parallel compare of every slot
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = valid_q[g] && (ent_q[g].vpn == look_vpn);
    assign kill_vec[g]  = inval_valid && valid_q[g] && (ent_q[g].vpn == inval_vpn);
  end

  assign look_hit  = |match_vec;
  assign valid_vec = valid_q;

  always_comb begin
    look_pfn = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match_vec[i]) look_pfn = look_pfn | ent_q[i].pfn;
  end

  // lowest empty slot first, round-robin victim when full
  always_comb begin
    victim = rr_q;
    use_rr = 1'b1;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        victim = PTR_W'(i);
        use_rr = 1'b0;
      end
    end
  end

  always_comb begin
    rr_d = rr_q;
    if (fill_en && use_rr)
      rr_d = (rr_q == PTR_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  end

  always_comb begin
    valid_d = valid_q & ~kill_vec;
    if (fill_en) valid_d[victim] = 1'b1;
    if (flush)   valid_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else begin
      valid_q <= valid_d;
      rr_q    <= rr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) ent_q[victim] <= '{vpn: fill_vpn, pfn: fill_pfn};
  end
endmodule

// File: rtl/tlbw_walk.sv
module tlbw_walk
  import tlbw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VA_W-1:0]  start_vaddr,
  input  logic [PN_W-1:0]  start_dir,
  output logic             idle,
  output logic             mem_req_valid,
  output logic [VA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PN_W-1:0]  rsp_frame,
  input  logic             rsp_present,
  output logic             fill_en,
  output logic [PN_W-1:0]  fill_vpn,
  output logic [PN_W-1:0]  fill_pfn,
  output logic             done,
  output logic             done_fault,
  output logic [VA_W-1:0]  done_paddr
);
  walk_st_t          st_q, st_d;
  logic [VA_W-1:0]   va_q;
  logic [PN_W-1:0]   dir_q, tbase_q;
  logic              cap_req, cap_tbase;

  assign idle      = (st_q == WK_IDLE);
  assign cap_req   = idle && start;
  assign cap_tbase = (st_q == WK_DIR) && mem_rsp_valid;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      WK_IDLE: if (start) st_d = WK_DIR;
      WK_DIR:  if (mem_rsp_valid) st_d = rsp_present ? WK_TBL : WK_IDLE;
      WK_TBL:  if (mem_rsp_valid) st_d = WK_IDLE;
      default: st_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= WK_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (cap_req) begin
      va_q  <= start_vaddr;
      dir_q <= start_dir;
    end
    if (cap_tbase) tbase_q <= rsp_frame;
  end

  assign mem_req_valid = !idle;
  assign mem_req_addr  = (st_q == WK_DIR)
                       ? {dir_q,   va_q[VA_W-1 -: IDX_W],         2'b00}
                       : {tbase_q, va_q[VA_W-IDX_W-1 -: IDX_W],   2'b00};

  assign fill_en    = (st_q == WK_TBL) && mem_rsp_valid && rsp_present;
  assign fill_vpn   = va_q[VA_W-1:OFF_W];
  assign fill_pfn   = rsp_frame;
  assign done       = mem_rsp_valid &&
                      ((st_q == WK_TBL) || ((st_q == WK_DIR) && !rsp_present));
  assign done_fault = !rsp_present;
  assign done_paddr = rsp_present ? {rsp_frame, va_q[OFF_W-1:0]} : '0;
endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb
  import tlbw_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_vaddr,
  output logic        req_ready,
  input  logic [19:0] dir_base,
  input  logic        flush,
  input  logic        inval_valid,
  input  logic [19:0] inval_vpn,
  output logic        rsp_valid,
  output logic        rsp_hit,
  output logic        rsp_fault,
  output logic [31:0] rsp_paddr,
  output logic        mem_req_valid,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data
);
  logic               req_fire, look_hit, walk_start, walk_idle;
  logic [PN_W-1:0]    look_pfn, fill_vpn, fill_pfn;
  logic               fill_en, w_done, w_fault;
  logic [VA_W-1:0]    w_paddr;
  logic [ENTRIES-1:0] match_vec, valid_vec;
  logic               rv_d, rh_d, rf_d, rsp_load;
  logic [VA_W-1:0]    rp_d;
  logic               unused_rsp_bits;

  assign unused_rsp_bits = ^mem_rsp_data[OFF_W-1:1];

  assign req_ready  = walk_idle;
  assign req_fire   = req_valid && req_ready;
  assign walk_start = req_fire && !look_hit;

  tlbw_cam #(.ENTRIES(ENTRIES)) u_cam (
    .clk(clk), .rst_n(rst_n),
    .look_vpn(req_vaddr[VA_W-1:OFF_W]), .look_hit(look_hit), .look_pfn(look_pfn),
    .flush(flush), .inval_valid(inval_valid), .inval_vpn(inval_vpn),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .match_vec(match_vec), .valid_vec(valid_vec)
  );

  tlbw_walk u_walk (
    .clk(clk), .rst_n(rst_n),
    .start(walk_start), .start_vaddr(req_vaddr), .start_dir(dir_base),
    .idle(walk_idle),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid),
    .rsp_frame(mem_rsp_data[VA_W-1:OFF_W]), .rsp_present(mem_rsp_data[0]),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .done(w_done), .done_fault(w_fault), .done_paddr(w_paddr)
  );

  // response next state
  always_comb begin
    rv_d     = (req_fire && look_hit) || w_done;
    rsp_load = rv_d;
    rh_d     = req_fire && look_hit;
    rf_d     = !rh_d && w_fault;
    rp_d     = rh_d ? {look_pfn, req_vaddr[OFF_W-1:0]} : w_paddr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= rv_d;
  end

  always_ff @(posedge clk) begin
    if (rsp_load) begin
      rsp_hit   <= rh_d;
      rsp_fault <= rf_d;
      rsp_paddr <= rp_d;
    end
  end
endmodule

// File: rtl/xlate_tlb_chk.sv
module xlate_tlb_chk #(
  parameter int ENTRIES = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [31:0]        req_vaddr,
  input logic               req_ready,
  input logic               flush,
  input logic               inval_valid,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_fault,
  input logic [31:0]        rsp_paddr,
  input logic               mem_req_valid,
  input logic [31:0]        mem_req_addr,
  input logic               mem_rsp_valid,
  input logic               look_hit,
  input logic [ENTRIES-1:0] match_vec,
  input logic [ENTRIES-1:0] valid_vec
);
  // R1
  hit_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && look_hit) |=>
      (rsp_valid && rsp_hit && !rsp_fault && !mem_req_valid &&
       rsp_paddr[11:0] == $past(req_vaddr[11:0])));

  // R2
  dir_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !look_hit) |=>
      (mem_req_valid && mem_req_addr[11:0] == {$past(req_vaddr[31:22]), 2'b00}));

  // R5
  fault_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault && !$past(flush) && !$past(inval_valid)) |->
      (valid_vec == $past(valid_vec) && !rsp_hit && rsp_paddr == 32'd0));

  // R7
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec == '0));

  // R11
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));
endmodule

bind xlate_tlb xlate_tlb_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .req_ready(req_ready), .flush(flush), .inval_valid(inval_valid),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
  .rsp_paddr(rsp_paddr), .mem_req_valid(mem_req_valid),
  .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
  .look_hit(look_hit), .match_vec(match_vec), .valid_vec(valid_vec)
);

// File: tb/xlate_tlb_tb.sv
module xlate_tlb_tb;
  localparam int N = 16;
  localparam logic [19:0] DIR_FRAME = 20'h00080;

  logic        clk, rst_n;
  logic        req_valid, req_ready;
  logic [31:0] req_vaddr;
  logic [19:0] dir_base;
  logic        flush, inval_valid;
  logic [19:0] inval_vpn;
  logic        rsp_valid, rsp_hit, rsp_fault;
  logic [31:0] rsp_paddr;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;

  int n_chk, n_fail;

  xlate_tlb #(.ENTRIES(N)) u_dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // bench memory: directory at DIR_FRAME, tables elsewhere
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [9:0] k;
    k = a[11:2];
    if (a[31:12] == DIR_FRAME)
      return {20'h00100 + 20'(k), 11'd0, (k != 10'd5)};
    return {a[21:12] ^ 10'h2A5, k ^ 10'h13B, 11'd0, ((k % 7) != 6)};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // memory responder with varying delay
  logic [31:0] rd_log [2];
  int          rd_cnt;
  int          dly;
  logic [31:0] prev_addr;
  bit          prev_wait;
  always @(negedge clk) begin
    if (mem_rsp_valid) begin
      mem_rsp_valid = 1'b0;
      prev_wait = 1'b0;
    end else if (mem_req_valid) begin
      if (prev_wait) chk(mem_req_addr == prev_addr, "R12", "request address held",
                         mem_req_addr, prev_addr);
      if (dly == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_word(mem_req_addr);
        if (rd_cnt < 2) rd_log[rd_cnt] = mem_req_addr;
        rd_cnt++;
        dly = $urandom % 3;
        prev_wait = 1'b0;
      end else begin
        dly--;
        prev_wait = 1'b1;
        prev_addr = mem_req_addr;
      end
    end
  end

  // reference model of the cached set
  bit          m_v [N];
  logic [19:0] m_vpn [N];
  logic [19:0] m_pfn [N];
  int          m_rr;

  function automatic int m_find(input logic [19:0] vpn);
    for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == vpn) return i;
    return -1;
  endfunction

  function automatic void m_fill(input logic [19:0] vpn, input logic [19:0] pfn);
    int slot;
    slot = -1;
    for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
    if (slot < 0) begin
      slot = m_rr;
      m_rr = (m_rr + 1) % N;
    end
    m_v[slot] = 1'b1; m_vpn[slot] = vpn; m_pfn[slot] = pfn;
  endfunction

  task automatic do_flush();
    @(negedge clk) flush = 1'b1;
    @(negedge clk) flush = 1'b0;
    for (int i = 0; i < N; i++) m_v[i] = 1'b0;
  endtask

  task automatic do_inval(input logic [19:0] vpn);
    int s;
    @(negedge clk) begin inval_valid = 1'b1; inval_vpn = vpn; end
    @(negedge clk) inval_valid = 1'b0;
    s = m_find(vpn);
    if (s >= 0) m_v[s] = 1'b0;
  endtask

  // one translation; returns 1 if it was a hit
  task automatic xlate(input logic [31:0] va, input bit hold_busy, input string tag,
                       output bit was_hit);
    int          s, cyc;
    bit          busy_bad;
    logic [31:0] da, dw, ta, tw, ep;
    s = m_find(va[31:12]);
    was_hit = (s >= 0);
    @(negedge clk);
    chk(req_ready == 1'b1, "R11", "ready when idle", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_vaddr = va; rd_cnt = 0;
    @(negedge clk);
    if (hold_busy) req_vaddr = va ^ 32'h0040_1000;
    else req_valid = 1'b0;
    cyc = 1; busy_bad = 1'b0;
    while (!rsp_valid && cyc < 40) begin
      if (req_ready) busy_bad = 1'b1;
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    chk(rsp_valid, tag, "response arrived", 32'(cyc), 32'd0);
    chk(!busy_bad, "R11", "ready low during walk", 32'(busy_bad), 32'd0);
    if (was_hit) begin
      ep = {m_pfn[s], va[11:0]};
      chk(cyc == 1, "R1", "hit latency", 32'(cyc), 32'd1);
      chk(rsp_hit && !rsp_fault, "R1", "hit flags", {30'd0, rsp_hit, rsp_fault}, 32'd2);
      chk(rsp_paddr == ep, "R1", "hit paddr", rsp_paddr, ep);
      chk(rd_cnt == 0, "R1", "no read on hit", 32'(rd_cnt), 32'd0);
    end else begin
      da = {DIR_FRAME, va[31:22], 2'b00};
      dw = mem_word(da);
      chk(rd_log[0] == da, "R2", "directory address", rd_log[0], da);
      if (!dw[0]) begin
        chk(rd_cnt == 1, "R5", "single read on dir fault", 32'(rd_cnt), 32'd1);
        chk(rsp_fault && !rsp_hit && rsp_paddr == 0, "R5", "dir fault response",
            {rsp_paddr[29:0], rsp_hit, rsp_fault}, 32'd1);
      end else begin
        ta = {dw[31:12], va[21:12], 2'b00};
        tw = mem_word(ta);
        chk(rd_cnt == 2, "R3", "two reads", 32'(rd_cnt), 32'd2);
        chk(rd_log[1] == ta, "R3", "table address", rd_log[1], ta);
        if (!tw[0]) begin
          chk(rsp_fault && !rsp_hit && rsp_paddr == 0, "R6", "table fault response",
              {rsp_paddr[29:0], rsp_hit, rsp_fault}, 32'd1);
        end else begin
          ep = {tw[31:12], va[11:0]};
          chk(!rsp_fault && !rsp_hit, "R4", "walk flags", {30'd0, rsp_hit, rsp_fault}, 32'd0);
          chk(rsp_paddr == ep, "R4", "walk paddr", rsp_paddr, ep);
          m_fill(va[31:12], tw[31:12]);
        end
      end
    end
  endtask

  function automatic logic [31:0] va_of(input int d, input int t, input int off);
    return {10'(d), 10'(t), 12'(off)};
  endfunction

  initial begin
    int seed;
    bit h;
    seed = $urandom(32'd2024);
    n_chk = 0; n_fail = 0; m_rr = 0;
    for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; dir_base = DIR_FRAME;
    flush = 1'b0; inval_valid = 1'b0; inval_vpn = '0;
    mem_rsp_valid = 1'b0; mem_rsp_data = '0; rd_cnt = 0; dly = 0; prev_wait = 1'b0;
    prev_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && req_ready && !mem_req_valid, "R11", "reset state",
        {29'd0, rsp_valid, req_ready, mem_req_valid}, 32'd2);

    // R4: walk then hit
    xlate(va_of(1, 3, 12'h123), 1'b0, "R4", h);
    chk(!h, "R4", "first access misses", 32'(h), 32'd0);
    xlate(va_of(1, 3, 12'hABC), 1'b0, "R4", h);
    chk(h, "R4", "repeat access hits", 32'(h), 32'd1);
    // R5: directory fault, not cached
    xlate(va_of(5, 2, 12'h010), 1'b0, "R5", h);
    xlate(va_of(5, 2, 12'h020), 1'b0, "R5", h);
    chk(!h, "R5", "faulting page not cached", 32'(h), 32'd0);
    // R6: table fault, not cached
    xlate(va_of(0, 6, 12'h444), 1'b0, "R6", h);
    xlate(va_of(0, 6, 12'h448), 1'b0, "R6", h);
    chk(!h, "R6", "faulting page not cached", 32'(h), 32'd0);

    // R8: fill all slots, overflow, probe victims
    do_flush();
    m_rr = m_rr;
    for (int i = 0; i < N; i++) xlate(va_of(i / 5, i % 5, i), 1'b0, "R8", h);
    xlate(va_of(4, 0, 0), 1'b0, "R8", h);           // evicts slot 0
    xlate(va_of(0, 0, 8), 1'b0, "R8", h);           // slot 0 page gone
    chk(!h, "R8", "round-robin victim evicted", 32'(h), 32'd0);
    xlate(va_of(0, 2, 8), 1'b0, "R8", h);           // slot 2 still cached
    chk(h, "R8", "non-victim kept", 32'(h), 32'd1);

    // R10: invalidate one page
    do_inval(20'({10'd0, 10'd2}));
    xlate(va_of(0, 2, 4), 1'b0, "R10", h);
    chk(!h, "R10", "invalidated page misses", 32'(h), 32'd0);
    xlate(va_of(0, 3, 4), 1'b0, "R10", h);
    chk(h, "R10", "other page kept", 32'(h), 32'd1);

    // R9: flush empties all
    do_flush();
    xlate(va_of(0, 3, 4), 1'b0, "R9", h);
    chk(!h, "R9", "miss after flush", 32'(h), 32'd0);

    // R11: request held during a walk
    xlate(va_of(2, 7, 12'h0F0), 1'b1, "R11", h);
    chk(!h, "R11", "held walk was a miss", 32'(h), 32'd0);

    // random traffic
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom % 100;
      if (op < 5) do_flush();
      else if (op < 12) do_inval({10'($urandom % 6), 10'($urandom % 12)});
      else xlate(va_of($urandom % 6, $urandom % 12, $urandom % 4096),
                 bit'($urandom % 2), "R1", h);
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule